// File: doc/BRIEF.md
# Counter-Addressed Serial-Load Latch Bank

This block is a bank of single-bit storage cells that is loaded one bit at a time. A serial data bit is written into whichever cell an internal address counter points at. Software or a neighbouring controller steps the counter by pulsing an advance input. Each falling edge of that input moves the pointer one place, and after the last cell the pointer wraps back to the first. The whole bank is presented in parallel on an output bus. That bus is driven only while the active-low output enable is asserted and floats otherwise, so several banks can share one set of wires.

An active-low "last position" flag is pulled low while the pointer sits on the final cell and is released otherwise. The flag of several banks can therefore be tied together with one pull-up. All control inputs are sampled on one system clock. The advance input may come from another clock domain and passes through a synchroniser before its edge is detected. A synchronous active-low reset empties the bank and returns the pointer to cell 0.

Top module: `serial_latch_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all cells clear to 0 and the pointer returns to 0. After reset the bus reads 0x00 when enabled and `full_n` is released.
- R2: When `strobe` is high at a rising clock edge, the cell at the pointer takes `data_in`. Every other cell keeps its value. Cell k appears on `bus_out[k]`.
- R3: When `strobe` is low, no cell changes, whatever `data_in` does.
- R4: Each high-to-low transition of `incr` moves the pointer up by exactly one, however long either level lasts. A low-to-high transition does not move it. The move takes effect at the third rising clock edge that samples `incr` low.
- R5: From the last position (7 with the default width) the next advance wraps the pointer to 0.
- R6: `full_n` is driven to 0 exactly while the pointer equals the last position. In every other position it is high impedance.
- R7: While `out_en_n` is low, `bus_out` carries all cells in parallel. While it is high, every bit of `bus_out` is high impedance.
- R8: If a write and a pointer move fall on the same clock edge, the write goes to the cell addressed before the move.
- R9: `out_en_n` gates only the bus drivers. Writes, pointer moves and `full_n` behave the same while the bus floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all control inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 1 | Serial bit to store |
| strobe | input | 1 | Write request for the addressed cell |
| incr | input | 1 | Pointer advance; falling edge steps the pointer (asynchronous, synchronised inside) |
| out_en_n | input | 1 | Active-low enable of the parallel bus drivers |
| bus_out | output | 2**ADDR_W | Parallel cell contents, or high impedance |
| full_n | output | 1 | Drive-low-only last-position flag |

## Verification
The bench builds the block with its default parameters: a 3-bit pointer over eight cells and a two-stage synchroniser. With these values a full load, the last-position flag and the wrap back to cell 0 are all reached within a few hundred cycles. The fixed synchroniser depth pins down the edge on which an advance lands. That makes it possible to align a write with a pointer move on the same clock edge. The bench places pull-ups on the bus and the flag, so a floating output is read as ones. It checks released states against cell contents that are not all ones.

// File: rtl/slb_pkg.sv
// Package: shared defaults for the serial-load latch bank.
// Assumes: pointer width and synchroniser depth are the only sizing knobs.
package slb_pkg;
    localparam int DEF_ADDR_W      = 3;
    localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/slb_edge_sync.sv
// Module: slb_edge_sync
// Synchronises the asynchronous advance input and emits a one-cycle pulse
// for every high-to-low transition seen on the synchronised copy.
// Assumes: STAGES >= 2; incr levels last longer than one clock period.
module slb_edge_sync #(
    parameter int STAGES = slb_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic fall_pulse
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw_in};
        end
    end

    // Keep the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // Falling edge: previous sample high, current sample low.
    assign fall_pulse = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/slb_addr_counter.sv
// Module: slb_addr_counter
// Wrapping write pointer with a last-position indication.
// Assumes: step is a one-cycle pulse; wrap relies on natural overflow.
module slb_addr_counter #(
    parameter int ADDR_W = slb_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_POS = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    // Advance by one per step pulse, wrapping past the last position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == LAST_POS);
endmodule

// File: rtl/slb_cell_array.sv
// Module: slb_cell_array
// Bank of single-bit cells; one addressed cell is written per strobe.
// Assumes: wr_addr is stable for the clock edge it is sampled on.
module slb_cell_array #(
    parameter int ADDR_W = slb_pkg::DEF_ADDR_W,
    localparam int CELLS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    output logic [CELLS-1:0]  cells
);
    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        logic cell_q;

        // Load this cell when it is addressed and the strobe is up.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else if (wr_en && (wr_addr == ADDR_W'(k))) begin
                cell_q <= wr_data;
            end
        end

        assign cells[k] = cell_q;
    end
endmodule

// File: rtl/slb_out_drive.sv
// Module: slb_out_drive
// Three-state bus drivers and the drive-low-only flag output.
// Assumes: an external pull-up defines released lines.
module slb_out_drive #(
    parameter int WIDTH = 8
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] value,
    input  logic             flag_act,
    output logic [WIDTH-1:0] bus,
    output logic             flag_n
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_drv
        assign bus[k] = oe_n ? 1'bz : value[k];
    end

    assign flag_n = flag_act ? 1'b0 : 1'bz;
endmodule

// File: rtl/serial_latch_bank.sv
// Module: serial_latch_bank (top)
// Serial-load bank of single-bit cells addressed by an internal pointer
// stepped on falling edges of incr; parallel three-state readout and a
// shareable last-position flag.
// Assumes: strobe and data_in are synchronous to clk; incr may be asynchronous.
module serial_latch_bank #(
    parameter int ADDR_W      = slb_pkg::DEF_ADDR_W,
    parameter int SYNC_STAGES = slb_pkg::DEF_SYNC_STAGES,
    localparam int CELLS      = 1 << ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_in,
    input  logic             strobe,
    input  logic             incr,
    input  logic             out_en_n,
    output logic [CELLS-1:0] bus_out,
    output logic             full_n
);
    logic              step_pulse;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_last;
    logic [CELLS-1:0]  cell_bits;

    slb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (incr),
        .fall_pulse (step_pulse)
    );

    slb_addr_counter #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_pulse),
        .addr    (ptr),
        .at_last (ptr_last)
    );

    slb_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (strobe),
        .wr_addr (ptr),
        .wr_data (data_in),
        .cells   (cell_bits)
    );

    slb_out_drive #(.WIDTH(CELLS)) u_drv (
        .oe_n     (out_en_n),
        .value    (cell_bits),
        .flag_act (ptr_last),
        .bus      (bus_out),
        .flag_n   (full_n)
    );
endmodule

// File: rtl/slb_checker.sv
// Module: slb_checker
// Property checks for serial_latch_bank, attached with bind.
// Assumes: reset is held for at least two clock edges at start-up.
module slb_checker #(
    parameter int ADDR_W = 3,
    localparam int CELLS = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              data_in,
    input logic [ADDR_W-1:0] ptr,
    input logic              ptr_last,
    input logic [CELLS-1:0]  cell_bits
);
    localparam logic [ADDR_W-1:0] LAST_POS = {ADDR_W{1'b1}};

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cell_bits == '0 && ptr == '0));

    a_r2_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> cell_bits[$past(ptr)] == $past(data_in));

    a_r2_single_cell: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> $countones(cell_bits ^ $past(cell_bits)) <= 1);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(cell_bits));

    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> ptr == ADDR_W'($past(ptr) + 1'b1));

    a_r6_full_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ptr_last) |-> (ptr == LAST_POS && $past(ptr) == LAST_POS - 1'b1));
endmodule

bind serial_latch_bank slb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .data_in   (data_in),
    .ptr       (ptr),
    .ptr_last  (ptr_last),
    .cell_bits (cell_bits)
);

// File: tb/serial_latch_bank_test.sv
module serial_latch_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_in = 1'b0;
    logic       strobe = 1'b0;
    logic       incr = 1'b1;
    logic       out_en_n = 1'b0;
    wire  [7:0] bus_w;
    wire        full_w;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_bits;
    int         exp_ptr;

    always #10 clk = ~clk;  // 50 MHz

    pullup (full_w);
    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (bus_w[i]);
    end

    serial_latch_bank uut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .strobe(strobe),
        .incr(incr), .out_en_n(out_en_n), .bus_out(bus_w), .full_n(full_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One strobed write at the current pointer.
    task automatic write_bit(input logic d);
        @(negedge clk);
        strobe = 1'b1; data_in = d;
        @(negedge clk);
        strobe = 1'b0; data_in = ~d;
        exp_bits[exp_ptr] = d;
    endtask

    // Full low-then-high pulse on incr; pointer moves once.
    task automatic pulse_incr();
        @(negedge clk);
        incr = 1'b0;
        wait_neg(5);
        incr = 1'b1;
        wait_neg(4);
        exp_ptr = (exp_ptr + 1) % 8;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        exp_bits = 8'h00; exp_ptr = 0;
        wait_neg(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bus after reset", {24'd0, bus_w}, 32'h00);
        chk("R1 full released after reset", {31'd0, full_w}, 32'd1);
    endtask

    task automatic t_fill();
        logic [7:0] pat = 8'hA5;
        for (int i = 0; i < 8; i++) begin
            write_bit(pat[i]);
            if (i == 6) chk("R6 full released at position 6", {31'd0, full_w}, 32'd1);
            if (i < 7) pulse_incr();
        end
        chk("R2 R7 parallel pattern", {24'd0, bus_w}, {24'd0, exp_bits});
        chk("R6 full driven at position 7", {31'd0, full_w}, 32'd0);
    endtask

    task automatic t_wrap();
        pulse_incr();
        chk("R5 R6 full released after wrap", {31'd0, full_w}, 32'd1);
        write_bit(1'b0);
        chk("R5 write lands in cell 0", {24'd0, bus_w}, 32'hA4);
    endtask

    task automatic t_nostrobe();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            data_in = i[0];
        end
        wait_neg(1);
        chk("R3 no change without strobe", {24'd0, bus_w}, {24'd0, exp_bits});
    endtask

    task automatic t_one_step();
        // long levels still give exactly one advance (pointer 0 -> 1)
        @(negedge clk);
        incr = 1'b0;
        wait_neg(12);
        incr = 1'b1;
        wait_neg(12);
        exp_ptr = 1;
        write_bit(1'b1);
        chk("R4 single advance per falling edge", {24'd0, bus_w}, 32'hA6);
    endtask

    task automatic t_same_edge();
        // pointer at 1; strobe meets the advance edge
        @(negedge clk);
        incr = 1'b0;
        wait_neg(2);
        strobe = 1'b1; data_in = 1'b0;
        @(negedge clk);
        strobe = 1'b0; data_in = 1'b1;
        exp_bits[1] = 1'b0;
        exp_ptr = 2;
        chk("R8 write used old pointer", {24'd0, bus_w}, 32'hA4);
        incr = 1'b1;
        wait_neg(4);
        write_bit(1'b0);
        chk("R8 pointer advanced after shared edge", {24'd0, bus_w}, 32'hA0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        out_en_n = 1'b1;
        wait_neg(1);
        chk("R7 bus floats when disabled", {24'd0, bus_w}, 32'hFF);
        write_bit(1'b1);
        pulse_incr();
        write_bit(1'b1);
        @(negedge clk);
        out_en_n = 1'b0;
        wait_neg(1);
        chk("R9 writes and advance while disabled", {24'd0, bus_w}, 32'hAC);
        @(negedge clk);
        out_en_n = 1'b1;
        for (int i = 0; i < 4; i++) pulse_incr();
        chk("R9 R6 full driven while bus disabled", {31'd0, full_w}, 32'd0);
        @(negedge clk);
        out_en_n = 1'b0;
    endtask

    task automatic t_reset_again();
        do_reset();
        chk("R1 cells cleared by later reset", {24'd0, bus_w}, 32'h00);
        chk("R1 pointer back to 0", {31'd0, full_w}, 32'd1);
        write_bit(1'b1);
        chk("R1 R2 write after reset lands in cell 0", {24'd0, bus_w}, 32'h01);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_fill();
        t_wrap();
        t_nostrobe();
        t_one_step();
        t_same_edge();
        t_disabled();
        t_reset_again();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule